// File: doc/BRIEF.md
# Hardware Breakpoint and Program-Counter Trace Unit

This unit sits beside an 8-bit processor core with a 16-bit address space. It raises an interrupt request when the core's instruction-fetch address or data-access address matches one of several programmed breakpoint slots. It can also raise one after every completed instruction when single-stepping is switched on. Because the match is made in hardware against the bus, no breakpoint opcode is ever patched into program memory. Breakpoints therefore work on code held in read-only memory.

Each slot holds an address, an enable bit and a type bit that selects either fetch matching or data matching. All slots are compared in parallel. A hit sets a sticky per-slot flag that software clears by writing a one to it. After a slot fires, it stays quiet until the program counter has moved off the breakpoint address, so execution can resume past it. A circular history of recent fetch addresses is kept while no breakpoint flag is set. Recording freezes once a breakpoint fires, so the history shows the path that led there. It is read back through an index register and a data register.

Top module: `dbg_break_unit`

## Requirements
- R1: A fetch strobe whose address equals the address of a slot with enable bit 0 set and type bit 1 clear sets that slot's status flag at the next clock edge, and irq is high from that edge on. A slot with its enable bit clear never sets its flag.
- R2: Register map for 4 slots. Offsets 0..3 hold the slot addresses. Offsets 4..7 hold slot control (bit 0 enable, bit 1 type, 1 = data). Offset 8 is status. Offset 9 is control (bit 0 single-step enable). Offset 10 is the trace index. Offset 11 is trace data. All of them read back through reg_rdata combinationally, and every register is zero after reset.
- R3: All slots are compared in the same cycle, so two slots with the same address both set their flags on one fetch. No flag is set in a cycle with no fetch or data strobe.
- R4: A slot with type bit set matches only data_valid with data_addr. A slot with type bit clear matches only fetch_valid with fetch_addr.
- R5: Status bits 0..3 are the slot hit flags and bit 4 is the step flag. They are sticky. Writing 1 to a bit at offset 8 clears only that bit. irq is high exactly while any status bit is set.
- R6: With step enable set, insn_done sets status bit 4 at the next edge. With step enable clear, insn_done sets nothing.
- R7: The step flag is not set while irq_disable is high.
- R8: Every fetch strobe while no slot hit flag is set writes fetch_addr into a 16-entry circular history, overwriting the oldest entry.
- R9: While any slot hit flag is set, the history is frozen; the fetch that causes the hit is still recorded. The step flag does not freeze it. Clearing all hit flags resumes recording.
- R10: Reading offset 11 returns the history entry that is (trace index) fetches older than the newest, so index 0 is the newest entry.
- R11: After a slot fires, it does not fire again until a fetch to a different address has been seen (for a data slot, any later fetch). A write to the slot's address or control register also re-arms it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Opcode fetch strobe for the current cycle |
| fetch_addr | input | 16 | Program counter of the fetch |
| data_valid | input | 1 | Data access strobe |
| data_addr | input | 16 | Address of the data access |
| insn_done | input | 1 | Pulses when an instruction completes |
| irq_disable | input | 1 | Processor interrupt-disable flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt request to the processor |

## Verification
A wrong comparator or a stuck re-arm lock shows up as a status word and irq that differ from the expected flags one edge after the offending strobe. The bench reads the status register on every random cycle, so this kind of fault is caught within a cycle. A broken write pointer or a freeze that comes too early or too late is invisible until the history is read. It then shows as misordered or stale entries at particular indices, which the bench checks after directed fetch runs and at the end of the random phase.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
   // slot control field positions
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_DATA_BIT = 1;
   // control register field
   localparam int CONTROL_STEP_BIT = 0;

   typedef struct packed {
      logic is_data;
      logic en;
   } slot_ctrl_t;
endpackage

// File: rtl/dbg_bp_slot.sv
module dbg_bp_slot
   import dbg_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              data_valid,
   input  logic [ADDR_W-1:0] data_addr,
   output logic [ADDR_W-1:0] bp_addr,
   output slot_ctrl_t        ctrl,
   output logic              fire
);
   logic lock_q;
   logic match;

   always_comb begin
      if (ctrl.is_data) match = data_valid  && (data_addr  == bp_addr);
      else              match = fetch_valid && (fetch_addr == bp_addr);
      fire = ctrl.en && match && !lock_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bp_addr <= '0;
         ctrl    <= '0;
      end else begin
         if (wr_addr) bp_addr <= wdata[ADDR_W-1:0];
         if (wr_ctrl) begin
            ctrl.en      <= wdata[CTRL_EN_BIT];
            ctrl.is_data <= wdata[CTRL_DATA_BIT];
         end
      end
   end

   // re-arm lock: set on a hit, released once the PC leaves the spot
   always_ff @(posedge clk) begin
      if (!rst_n)                 lock_q <= 1'b0;
      else if (wr_addr || wr_ctrl) lock_q <= 1'b0;
      else if (fire)               lock_q <= 1'b1;
      else if (fetch_valid && (ctrl.is_data || fetch_addr != bp_addr))
                                   lock_q <= 1'b0;
   end
endmodule

// File: rtl/dbg_trace.sv
module dbg_trace #(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rec,
   input  logic [ADDR_W-1:0] pc,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_pc,
   output logic [PTR_W-1:0]  wr_ptr
);
   logic [ADDR_W-1:0] hist [DEPTH];
   logic [PTR_W-1:0]  rd_slot;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      end else if (rec) begin
         hist[wr_ptr] <= pc;
         wr_ptr       <= wr_ptr + PTR_W'(1);
      end
   end

   always_comb begin
      rd_slot = wr_ptr - PTR_W'(1) - rd_idx;
      rd_pc   = hist[rd_slot];
   end
endmodule

// File: rtl/dbg_break_unit.sv
module dbg_break_unit
   import dbg_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int NUM_SLOTS   = 4,
   parameter int TRACE_DEPTH = 16,
   parameter int REG_AW      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              data_valid,
   input  logic [ADDR_W-1:0] data_addr,
   input  logic              insn_done,
   input  logic              irq_disable,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int TPTR_W      = $clog2(TRACE_DEPTH);
   localparam int REG_CTRL0   = NUM_SLOTS;
   localparam int REG_STATUS  = 2 * NUM_SLOTS;
   localparam int REG_CONTROL = REG_STATUS + 1;
   localparam int REG_TIDX    = REG_STATUS + 2;
   localparam int REG_TDATA   = REG_STATUS + 3;
   localparam int STEP_BIT    = NUM_SLOTS;

   if (ADDR_W > DATA_W) begin : g_bad_aw
      $error("ADDR_W must not exceed DATA_W");
   end
   if (NUM_SLOTS + 1 > DATA_W) begin : g_bad_slots
      $error("status word too narrow for NUM_SLOTS");
   end
   if (REG_TDATA >= (1 << REG_AW)) begin : g_bad_map
      $error("REG_AW too small for register map");
   end
   if (TRACE_DEPTH < 2 || (TRACE_DEPTH & (TRACE_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("TRACE_DEPTH must be a power of two of at least 2");
   end

   logic [ADDR_W-1:0]    slot_addr [NUM_SLOTS];
   slot_ctrl_t           slot_ctrl [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] fire;
   logic [NUM_SLOTS-1:0] hit_q;
   logic [NUM_SLOTS-1:0] hit_clr;
   logic                 step_q;
   logic                 step_en_q;
   logic [TPTR_W-1:0]    tidx_q;
   logic [TPTR_W-1:0]    trace_ptr;
   logic [ADDR_W-1:0]    trace_pc;
   logic                 status_we;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      dbg_bp_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_addr    (reg_we && reg_addr == REG_AW'(s)),
         .wr_ctrl    (reg_we && reg_addr == REG_AW'(REG_CTRL0 + s)),
         .wdata      (reg_wdata),
         .fetch_valid(fetch_valid),
         .fetch_addr (fetch_addr),
         .data_valid (data_valid),
         .data_addr  (data_addr),
         .bp_addr    (slot_addr[s]),
         .ctrl       (slot_ctrl[s]),
         .fire       (fire[s])
      );
   end

   assign status_we = reg_we && reg_addr == REG_AW'(REG_STATUS);
   assign hit_clr   = status_we ? reg_wdata[NUM_SLOTS-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q     <= '0;
         step_q    <= 1'b0;
         step_en_q <= 1'b0;
         tidx_q    <= '0;
      end else begin
         hit_q  <= (hit_q & ~hit_clr) | fire;
         step_q <= (step_q && !(status_we && reg_wdata[STEP_BIT]))
                   || (step_en_q && insn_done && !irq_disable);
         if (reg_we && reg_addr == REG_AW'(REG_CONTROL))
            step_en_q <= reg_wdata[CONTROL_STEP_BIT];
         if (reg_we && reg_addr == REG_AW'(REG_TIDX))
            tidx_q <= reg_wdata[TPTR_W-1:0];
      end
   end

   dbg_trace #(.ADDR_W(ADDR_W), .DEPTH(TRACE_DEPTH)) u_trace (
      .clk   (clk),
      .rst_n (rst_n),
      .rec   (fetch_valid && hit_q == '0),
      .pc    (fetch_addr),
      .rd_idx(tidx_q),
      .rd_pc (trace_pc),
      .wr_ptr(trace_ptr)
   );

   always_comb begin
      reg_rdata = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (reg_addr == REG_AW'(s))
            reg_rdata = DATA_W'(slot_addr[s]);
         if (reg_addr == REG_AW'(REG_CTRL0 + s))
            reg_rdata = DATA_W'({slot_ctrl[s].is_data, slot_ctrl[s].en});
      end
      if (reg_addr == REG_AW'(REG_STATUS))  reg_rdata = DATA_W'({step_q, hit_q});
      if (reg_addr == REG_AW'(REG_CONTROL)) reg_rdata = DATA_W'(step_en_q);
      if (reg_addr == REG_AW'(REG_TIDX))    reg_rdata = DATA_W'(tidx_q);
      if (reg_addr == REG_AW'(REG_TDATA))   reg_rdata = DATA_W'(trace_pc);
   end

   assign irq = (hit_q != '0) || step_q;
endmodule

// File: rtl/dbg_break_chk.sv
module dbg_break_chk #(
   parameter int NUM_SLOTS = 4,
   parameter int PTR_W     = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 fetch_valid,
   input logic                 data_valid,
   input logic                 insn_done,
   input logic                 irq_disable,
   input logic                 reg_we,
   input logic                 irq,
   input logic [NUM_SLOTS-1:0] hit_q,
   input logic                 step_q,
   input logic [PTR_W-1:0]     trace_ptr
);
   AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(fetch_valid || data_valid || insn_done)); // R1

   AST_NO_STROBE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(fetch_valid || data_valid) |-> ((hit_q & ~$past(hit_q)) == '0)); // R3

   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq) && !$past(reg_we)) |-> irq); // R5

   AST_STEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(step_q) && $past(irq_disable)) |-> !step_q); // R7

   AST_TRACE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hit_q != '0) |-> $stable(trace_ptr)); // R9
endmodule

bind dbg_break_unit dbg_break_chk #(.NUM_SLOTS(NUM_SLOTS), .PTR_W(TPTR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fetch_valid(fetch_valid),
   .data_valid (data_valid),
   .insn_done  (insn_done),
   .irq_disable(irq_disable),
   .reg_we     (reg_we),
   .irq        (irq),
   .hit_q      (hit_q),
   .step_q     (step_q),
   .trace_ptr  (trace_ptr)
);

// File: tb/test_dbg_break_unit.sv
`timescale 1ns/1ps
module test_dbg_break_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        fetch_valid, data_valid, insn_done, irq_disable, reg_we;
   logic [15:0] fetch_addr, data_addr, reg_wdata;
   logic [3:0]  reg_addr;
   logic [15:0] reg_rdata;
   logic        irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // bench model state
   logic [15:0] m_addr [4];
   logic [3:0]  m_en, m_typ, m_lock, m_hit;
   logic        m_step, m_sten;
   logic [3:0]  m_tidx, m_ptr;
   logic [15:0] m_tr [16];

   always #2.5 clk = ~clk;

   dbg_break_unit i_dbg_break_unit (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .data_valid(data_valid), .data_addr(data_addr),
      .insn_done(insn_done), .irq_disable(irq_disable),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] m_status();
      return {11'b0, m_step, m_hit};
   endfunction

   task automatic model_reset();
      for (int s = 0; s < 4; s++) m_addr[s] = '0;
      for (int i = 0; i < 16; i++) m_tr[i] = '0;
      m_en = '0; m_typ = '0; m_lock = '0; m_hit = '0;
      m_step = 0; m_sten = 0; m_tidx = '0; m_ptr = '0;
   endtask

   // next state from the requirements, using the inputs now driven
   task automatic model_update();
      logic [3:0] fire;
      logic [3:0] clr;
      logic       wst;
      for (int s = 0; s < 4; s++) begin
         logic m;
         m = m_typ[s] ? (data_valid && data_addr == m_addr[s])
                      : (fetch_valid && fetch_addr == m_addr[s]);
         fire[s] = m_en[s] && m && !m_lock[s];
      end
      if (fetch_valid && m_hit == '0) begin
         m_tr[m_ptr] = fetch_addr;
         m_ptr = m_ptr + 4'd1;
      end
      for (int s = 0; s < 4; s++) begin
         if (reg_we && (reg_addr == 4'(s) || reg_addr == 4'(4 + s))) m_lock[s] = 0;
         else if (fire[s]) m_lock[s] = 1;
         else if (fetch_valid && (m_typ[s] || fetch_addr != m_addr[s])) m_lock[s] = 0;
      end
      wst    = reg_we && reg_addr == 4'd8;
      clr    = wst ? reg_wdata[3:0] : 4'd0;
      m_step = (m_step && !(wst && reg_wdata[4])) || (m_sten && insn_done && !irq_disable);
      m_hit  = (m_hit & ~clr) | fire;
      if (reg_we) begin
         for (int s = 0; s < 4; s++) begin
            if (reg_addr == 4'(s)) m_addr[s] = reg_wdata;
            if (reg_addr == 4'(4 + s)) begin
               m_en[s] = reg_wdata[0]; m_typ[s] = reg_wdata[1];
            end
         end
         if (reg_addr == 4'd9)  m_sten = reg_wdata[0];
         if (reg_addr == 4'd10) m_tidx = reg_wdata[3:0];
      end
   endtask

   task automatic tick();
      model_update();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      tick();
      reg_we = 0;
   endtask

   task automatic fetch(input logic [15:0] a);
      fetch_valid = 1; fetch_addr = a;
      tick();
      fetch_valid = 0;
   endtask

   task automatic dacc(input logic [15:0] a);
      data_valid = 1; data_addr = a;
      tick();
      data_valid = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic trace_at(input int idx, output logic [15:0] v);
      wr(4'd10, 16'(idx));
      rd(4'd11, v);
   endtask

   function automatic logic [15:0] pick();
      case ($urandom_range(0, 4))
         0: return 16'h8000;
         1: return 16'h0200;
         2: return 16'h1234;
         3: return 16'h8001;
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd20417));
      rst_n = 0; fetch_valid = 0; data_valid = 0; insn_done = 0; irq_disable = 0;
      reg_we = 0; reg_addr = 0; reg_wdata = 0; fetch_addr = 0; data_addr = 0;
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // reset state
      chk("R2 reset irq", irq, 0);
      rd(4'd8, v); chk("R2 reset status", v, 0);
      rd(4'd0, v); chk("R2 reset slot0 addr", v, 0);

      // fetch breakpoint on slot 0
      wr(4'd0, 16'h8000); wr(4'd4, 16'h0001);
      fetch_addr = 16'h8000; fetch_valid = 0; tick();
      rd(4'd8, v); chk("R3 no strobe no hit", v, 0);
      dacc(16'h8000);
      rd(4'd8, v); chk("R4 fetch slot ignores data", v, 0);
      fetch(16'h7FFE);
      chk("R1 no match irq", irq, 0);
      fetch(16'h8000);
      chk("R1 fetch match irq", irq, 1);
      rd(4'd8, v); chk("R5 status slot0", v, 16'h0001);
      wr(4'd8, 16'h0001);
      rd(4'd8, v); chk("R5 w1c clears", v, 0);
      chk("R5 irq low after clear", irq, 0);

      // re-arm lock
      fetch(16'h8000);
      rd(4'd8, v); chk("R11 same pc no refire", v, 0);
      fetch(16'h8002); fetch(16'h8000);
      rd(4'd8, v); chk("R11 refire after move", v, 16'h0001);
      wr(4'd8, 16'h0001);

      // disabled slot
      wr(4'd3, 16'h4444); fetch(16'h4444);
      rd(4'd8, v); chk("R1 disabled slot silent", v, 0);

      // data slot
      wr(4'd1, 16'h0200); wr(4'd5, 16'h0003);
      fetch(16'h0200);
      rd(4'd8, v); chk("R4 data slot ignores fetch", v, 0);
      dacc(16'h0200);
      rd(4'd8, v); chk("R4 data slot hit", v, 16'h0002);
      wr(4'd8, 16'h0002);

      // parallel slots
      wr(4'd2, 16'h5555); wr(4'd6, 16'h0001);
      wr(4'd3, 16'h5555); wr(4'd7, 16'h0001);
      fetch(16'h5555);
      rd(4'd8, v); chk("R3 two slots one fetch", v, 16'h000C);
      wr(4'd8, 16'h0004);
      rd(4'd8, v); chk("R5 partial clear", v, 16'h0008);
      wr(4'd8, 16'h0008);
      rd(4'd5, v); chk("R2 ctrl readback", v, 16'h0003);
      rd(4'd1, v); chk("R2 addr readback", v, 16'h0200);

      // single step
      wr(4'd9, 16'h0001);
      rd(4'd9, v); chk("R2 control readback", v, 16'h0001);
      insn_done = 1; irq_disable = 1; tick();
      rd(4'd8, v); chk("R7 step masked", v, 0);
      irq_disable = 0; tick(); insn_done = 0;
      rd(4'd8, v); chk("R6 step flag", v, 16'h0010);
      fetch(16'h0A00); fetch(16'h0A01);
      trace_at(0, v); chk("R9 step does not freeze", v, 16'h0A01);
      wr(4'd8, 16'h0010); wr(4'd9, 16'h0000);
      insn_done = 1; tick(); insn_done = 0;
      rd(4'd8, v); chk("R6 step off", v, 0);

      // trace wrap and freeze
      for (int i = 0; i < 20; i++) fetch(16'h1000 + 16'(i));
      for (int i = 0; i < 16; i++) begin
         trace_at(i, v);
         chk("R8 R10 history order", v, 16'h1013 - 16'(i));
      end
      fetch(16'h8000);
      fetch(16'h2000); fetch(16'h2001);
      trace_at(0, v); chk("R9 frozen newest is break pc", v, 16'h8000);
      trace_at(1, v); chk("R9 frozen prior entry", v, 16'h1013);
      wr(4'd8, 16'h0001);
      fetch(16'h3000);
      trace_at(0, v); chk("R9 rearmed newest", v, 16'h3000);
      trace_at(1, v); chk("R9 rearmed prior", v, 16'h8000);

      // constrained random against the model
      wr(4'd0, 16'h8000); wr(4'd4, 16'h0001);
      wr(4'd1, 16'h0200); wr(4'd5, 16'h0003);
      wr(4'd2, 16'h1234); wr(4'd6, 16'h0001);
      wr(4'd3, 16'h8001); wr(4'd7, 16'h0000);
      wr(4'd9, 16'h0001);
      for (int i = 0; i < 3000; i++) begin
         fetch_valid = 1'($urandom_range(0, 1));
         fetch_addr  = pick();
         data_valid  = ($urandom_range(0, 3) == 0);
         data_addr   = pick();
         insn_done   = 1'($urandom_range(0, 1));
         irq_disable = 1'($urandom_range(0, 1));
         reg_addr    = 4'd8;
         reg_we      = ($urandom_range(0, 5) == 0);
         reg_wdata   = 16'($urandom_range(0, 31));
         tick();
         reg_we = 0;
         #1;
         chk("R5 random status", reg_rdata, m_status());
         chk("R5 random irq", irq, (m_hit != 0) || m_step);
      end
      fetch_valid = 0; data_valid = 0; insn_done = 0;
      for (int i = 0; i < 16; i++) begin
         trace_at(i, v);
         chk("R8 random history", v, m_tr[4'(m_ptr - 4'd1 - 4'(i))]);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule